// File: doc/BRIEF.md
# Synchronous FIFO with Selectable Output Timing and Partial Reset

This block is a single-clock first-in first-out buffer for 36-bit words with a parameterized depth. It has two output timing behaviours. In standard timing, a word appears on the read data port only after an explicit read request. In fall-through timing, the oldest stored word is presented on the read data port without any request, and a read request discards it and advances to the next word. The choice between the two is made once, on the first rising clock edge after the full reset is released. It then stays fixed until the next full reset.

Two reset inputs are provided, and both are active low. The full reset empties the buffer and arms the timing-mode capture. The partial reset empties the buffer but keeps the timing mode that is already selected. This lets a system flush stale data without going through mode selection again. Each reset should be held low for at least four rising clock edges.

Two status pins serve both modes. The write-side pin means "not full" in standard timing and "input ready" in fall-through timing. The read-side pin means "not empty" in standard timing and "output ready" in fall-through timing. Almost-empty and almost-full indications use fixed thresholds that are set by parameters.

Top module: `dm_fifo`

## Requirements
- R1: While either reset input is low, `wr_rdy` is 0, `rd_rdy` is 0, `aempty_n` is 0 and `afull_n` is 1.
- R2: After the last reset input returns high, `wr_rdy` stays 0 following the first rising edge and becomes 1 following the second rising edge. Writes are ignored while `wr_rdy` is 0.
- R3: The level of `mode_sel` at the first rising edge after `rst_n` returns high sets the timing mode: 1 selects standard timing and 0 selects fall-through timing. Changes to `mode_sel` at any other time have no effect.
- R4: In standard timing, `rd_rdy` is 1 after the edge that writes into an empty buffer. A word reaches `rd_data` only after the edge that accepts a read request. Words come out in the order they were written.
- R5: In fall-through timing, a word written into an empty buffer is on `rd_data`, with `rd_rdy` at 1, two rising edges after the write, with no read request. A read request discards the presented word and presents the next one after the same edge.
- R6: `wr_rdy` is 0 when the occupancy equals DEPTH. A write attempted at that time stores nothing and moves no pointer.
- R7: A read request while `rd_rdy` is 0 has no effect on the contents or the pointers.
- R8: Occupancy counts the stored words, including the word presented in fall-through timing. `aempty_n` is 0 exactly when occupancy ≤ AE_LVL. `afull_n` is 0 exactly when occupancy ≥ DEPTH − AF_LVL.
- R9: A partial reset empties the buffer and leaves the selected timing mode unchanged, even if `mode_sel` changes during or after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Full reset, active low; arms the mode capture |
| prst_n | input | 1 | Partial reset, active low; keeps the mode |
| mode_sel | input | 1 | Timing mode choice (1 standard, 0 fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Read data |
| wr_rdy | output | 1 | Not-full / input-ready |
| rd_rdy | output | 1 | Not-empty / output-ready |
| aempty_n | output | 1 | Almost-empty, active low |
| afull_n | output | 1 | Almost-full, active low |

## Verification
The hardest condition to reach from the ports is proving that a partial reset kept the mode. Both modes look the same at reset and at rest. They differ only in the one-edge gap between a write into an empty buffer and `rd_rdy` rising. The stimulus therefore loads data, applies the partial reset with `mode_sel` driven to the opposite level, and writes a single word afterwards. It then samples `rd_rdy` right after that write edge. The same latency probe, with `mode_sel` flipped right after the capture edge, shows that the mode was captured on that edge alone.

// File: rtl/dm_fifo.sv
module dm_fifo #(
  parameter int WIDTH  = 36,
  parameter int DEPTH  = 8,
  parameter int AE_LVL = 2,
  parameter int AF_LVL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prst_n,
  input  logic             mode_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             wr_rdy,
  output logic             rd_rdy,
  output logic             aempty_n,
  output logic             afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt, occ;
  logic [1:0]       warm;
  logic             std_mode, mode_arm, hold_v;
  logic             live, wr_ok, rd_ok, pop;

  assign live  = rst_n && prst_n;
  assign occ   = cnt + CW'(hold_v);
  assign wr_ok = wr_en && wr_rdy;
  assign rd_ok = rd_en && rd_rdy;
  assign pop   = std_mode ? rd_ok : (cnt != '0) && (!hold_v || rd_ok);

  assign wr_rdy   = live && warm == 2'd2 && occ < CW'(DEPTH);
  assign rd_rdy   = live && (std_mode ? cnt != '0 : hold_v);
  assign aempty_n = live && occ > CW'(AE_LVL);
  assign afull_n  = !live || occ < CW'(DEPTH - AF_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_arm <= 1'b1;
      std_mode <= 1'b1;
    end else if (mode_arm) begin
      mode_arm <= 1'b0;
      std_mode <= mode_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!live) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      hold_v <= 1'b0;
      warm   <= 2'd0;
    end else begin
      if (warm != 2'd2) warm <= warm + 2'd1;
      if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)   rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(pop);
      if (!std_mode) hold_v <= pop ? 1'b1 : (rd_ok ? 1'b0 : hold_v);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (live && pop) rd_data <= mem[rptr];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!live)
    occ <= CW'(DEPTH)); // R6
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!live)
    (wr_en && !wr_rdy) |=> $stable(wptr)); // R6
  AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!live)
    (std_mode && rd_en && !rd_rdy && !wr_en) |=> $stable(rptr) && cnt == '0); // R7
  AST_PARTIAL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!prst_n && !mode_arm) |=> $stable(std_mode)); // R9
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!live)
    (!std_mode && !mode_arm && !rd_rdy && cnt != '0) |=> rd_rdy); // R5
  AST_RESET_FLAGS: assert property (@(posedge clk)
    !live |-> !wr_rdy && !rd_rdy && !aempty_n && afull_n); // R1
endmodule

// File: tb/dm_fifo_tb.sv
module dm_fifo_tb;
  localparam int W = 36, D = 8, AE = 2, AF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic wr_rdy, rd_rdy, aempty_n, afull_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dm_fifo #(.WIDTH(W), .DEPTH(D), .AE_LVL(AE), .AF_LVL(AF)) u_dut (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .wr_rdy(wr_rdy), .rd_rdy(rd_rdy), .aempty_n(aempty_n), .afull_n(afull_n));

  function automatic logic [W-1:0] pat(int i);
    return (W'(i + 1) * 36'h1_0204_0801) ^ 36'h5_A5A5_A5A5;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reset_flags(string req);
    check(req, W'(wr_rdy), 0);
    check(req, W'(rd_rdy), 0);
    check(req, W'(aempty_n), 0);
    check(req, W'(afull_n), 1);
  endtask

  task automatic occ_flags(int n);
    check("R6 wr_rdy", W'(wr_rdy), W'(n < D));
    check("R8 aempty_n", W'(aempty_n), W'(n > AE));
    check("R8 afull_n", W'(afull_n), W'(n < D - AF));
  endtask

  task automatic full_reset(logic std);
    rst_n = 1'b0;
    mode_sel = ~std;
    repeat (4) step();
    reset_flags("R1 full");
    rst_n = 1'b1;
    mode_sel = std;
    step();
    mode_sel = ~std;
    check("R2 first edge", W'(wr_rdy), 0);
    step();
    check("R2 second edge", W'(wr_rdy), 1);
  endtask

  task automatic write1(logic [W-1:0] v);
    wr_en = 1'b1;
    wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic run_mode(logic std);
    full_reset(std);
    write1(pat(100));
    check("R3 latency probe", W'(rd_rdy), W'(std));
    step();
    check("R4/R5 ready", W'(rd_rdy), 1);
    if (!std) check("R5 fall-through data", rd_data, pat(100));
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    if (std) check("R4 read data", rd_data, pat(100));
    check("R4/R5 empty after read", W'(rd_rdy), 0);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    check("R7 still empty", W'(rd_rdy), 0);
    write1(pat(200));
    step();
    if (!std) check("R7 head intact", rd_data, pat(200));
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    if (std) check("R7 read after empty read", rd_data, pat(200));
    check("R7 empty", W'(rd_rdy), 0);
    for (int i = 0; i < D; i++) begin
      write1(pat(i));
      occ_flags(i + 1);
    end
    write1(pat(99));
    check("R6 full write dropped", W'(wr_rdy), 0);
    for (int k = 0; k < D; k++) begin
      if (!std) check("R5 head order", rd_data, pat(k));
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
      if (std) check("R4 order", rd_data, pat(k));
      occ_flags(D - 1 - k);
    end
    check("R6 overflow word absent", W'(rd_rdy), 0);
    for (int i = 0; i < 3; i++) write1(pat(50 + i));
    prst_n = 1'b0;
    mode_sel = ~std;
    repeat (4) step();
    reset_flags("R1 partial");
    prst_n = 1'b1;
    step();
    check("R2 partial first edge", W'(wr_rdy), 0);
    step();
    check("R2 partial second edge", W'(wr_rdy), 1);
    check("R9 emptied", W'(rd_rdy), 0);
    write1(pat(300));
    check("R9 mode kept", W'(rd_rdy), W'(std));
    step();
    if (!std) check("R9 fall-through", rd_data, pat(300));
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    if (std) check("R9 data", rd_data, pat(300));
    check("R9 only new word", W'(rd_rdy), 0);
  endtask

  initial begin
    @(negedge clk);
    step();
    reset_flags("R1 initial");
    run_mode(1'b1);
    run_mode(1'b0);
    run_mode(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule